// File: doc/BRIEF.md
# Bipolar Line Error Counter

This block watches a dual-rail bipolar symbol stream, one symbol per slot marked by a slot-valid strobe, and counts line errors. It tracks the polarity of the last mark to spot bipolar violations (a mark with the same polarity as the mark before it). It then sets aside the violations that belong to legal zero-substitution codewords, using either 3-zero substitution rules or 4-zero (HDB3) substitution rules. Every remaining violation counts as an error.

A codeword-format control picks between two ways of recognising codewords. The first looks only at the run of zeros before the violation. The second also needs the violation to have the opposite polarity to the previous accepted codeword's violation. In HDB3 mode a separate enable replaces plain violation counting with counting of successive same-polarity violations. This enable has no effect in the 3-zero mode.

Errors feed a saturating counter. A latch strobe copies the counter to a holding output and restarts it. Each counted error also raises a one-clock pulse. The block keeps its own codeword history, so its format control can differ from that of any decoder sharing the stream.

Top module: `bpv_err_monitor`

## Requirements
- R1: In a slot with `sym_valid`=1, `rail_p`=1 with `rail_n`=0 is a positive mark and `rail_n`=1 with `rail_p`=0 is a negative mark. Both low or both high is a zero. A violation is a mark whose polarity equals that of the previous mark. The first mark after reset is never a violation.
- R2: With `cfg_hdb3`=0 (3-zero mode) and `cfg_track`=0, a violation directly preceded by at least one zero is a codeword and is not counted. Every other violation is counted.
- R3: With `cfg_hdb3`=1 and `cfg_track`=0, a violation directly preceded by at least two zeros is a codeword and is not counted. Every other violation is counted, including one preceded by a single zero.
- R4: With `cfg_track`=1, a codeword also needs its violation polarity to be opposite to that of the last accepted codeword. A violation that fails this test is counted.
- R5: After reset, the first codeword is accepted on the zero-run rule alone, whatever its polarity, even with `cfg_track`=1.
- R6: With `cfg_hdb3`=1 and `cfg_e3`=1, an error is counted only when a violation has the same polarity as the previous violation. The first violation after reset, and violations of alternating polarity, are not counted.
- R7: With `cfg_hdb3`=0, `cfg_e3` has no effect.
- R8: `err_pulse` is high for exactly the one clock after each slot that holds a counted error. Cycles with `sym_valid`=0 change neither the history nor the count.
- R9: The running count is 16 bits wide and holds at 65535 instead of wrapping.
- R10: On a clock where `latch_stb`=1, `held_count` takes the running count and the running count restarts. An error in that same slot becomes the first count of the new period. `held_count` changes only on a latch.
- R11: After reset, `held_count` is 0, `err_pulse` is 0, and the running count and all history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Marks a clock that carries a line symbol |
| rail_p | input | 1 | Positive-mark rail |
| rail_n | input | 1 | Negative-mark rail |
| cfg_hdb3 | input | 1 | 0: 3-zero substitution, 1: HDB3 |
| cfg_track | input | 1 | 1: codewords must alternate violation polarity |
| cfg_e3 | input | 1 | HDB3 only: count same-polarity violation pairs |
| latch_stb | input | 1 | Copy count to holding output and restart |
| err_pulse | output | 1 | One-clock pulse per counted error |
| held_count | output | 16 | Count captured at the last latch |

## Verification
The hardest state to reach is a codeword that has the right zero run but the wrong polarity. It needs one accepted codeword in the history, then a second codeword of the same polarity, with only legal alternating marks between them. The stimulus starts from reset and places a first codeword of each polarity. This shows that the first codeword is accepted under polarity tracking. It then repeats the same codeword shape and expects an error pulse exactly on the repeat. Saturation is reached by feeding an unbroken run of same-polarity marks, one error per slot, for more than 65535 slots before latching.

// File: rtl/bpvm_pkg.sv
// Package: shared types for the bipolar line error counter.
// Assumes one symbol per slot; the zero-run count only needs to reach 3.
package bpvm_pkg;
    localparam int ZRUN_W   = 2;
    localparam int ZRUN_MAX = (1 << ZRUN_W) - 1;

    // Per-slot facts handed from the symbol tracker to the codeword filter.
    typedef struct packed {
        logic              valid;   // slot carries a symbol
        logic              is_bpv;  // mark with same polarity as the previous mark
        logic              neg;     // polarity of the current mark (1 = negative)
        logic [ZRUN_W-1:0] zrun;    // zeros directly before this slot, saturating
    } slot_info_t;
endpackage

// File: rtl/bpvm_symbol_track.sv
// Module: bpvm_symbol_track
// Decodes the dual-rail symbol, remembers the last mark's polarity and the
// run of zeros since it, and flags bipolar violations in the current slot.
// Assumes: both rails high is taken as a zero; history moves only in valid slots.
module bpvm_symbol_track
    import bpvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_valid,
    input  logic       rail_p,
    input  logic       rail_n,
    output slot_info_t info
);
    logic              have_mark;
    logic              last_neg;
    logic [ZRUN_W-1:0] zrun_q;
    logic              is_mark;
    logic              cur_neg;

    // Classify the present symbol against the stored history.
    always_comb begin
        is_mark     = rail_p ^ rail_n;
        cur_neg     = rail_n & ~rail_p;
        info.valid  = sym_valid;
        info.neg    = cur_neg;
        info.zrun   = zrun_q;
        info.is_bpv = sym_valid & is_mark & have_mark & (cur_neg == last_neg);
    end

    // Update the mark polarity and zero-run history once per valid slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_mark <= 1'b0;
            last_neg  <= 1'b0;
            zrun_q    <= '0;
        end else if (sym_valid) begin
            if (is_mark) begin
                have_mark <= 1'b1;
                last_neg  <= cur_neg;
                zrun_q    <= '0;
            end else if (zrun_q != ZRUN_W'(ZRUN_MAX)) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    // A zero symbol can never be a violation (R1).
    p_zero_not_bpv_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && (rail_p == rail_n)) |-> !info.is_bpv);
endmodule

// File: rtl/bpvm_cw_filter.sv
// Module: bpvm_cw_filter
// Separates violations that belong to substitution codewords from real errors,
// or, in the same-polarity mode, flags violations matching the prior violation.
// Keeps a private history of the last accepted codeword and last violation.
// Assumes info comes from bpvm_symbol_track for the same slot.
module bpvm_cw_filter
    import bpvm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  slot_info_t info,
    input  logic       cfg_hdb3,
    input  logic       cfg_track,
    input  logic       cfg_e3,
    output logic       err
);
    logic              cw_seen;
    logic              cw_neg;
    logic              v_seen;
    logic              v_neg;
    logic              e3_act;
    logic [ZRUN_W-1:0] need_z;
    logic              shape_ok;
    logic              pol_ok;
    logic              is_cw;
    logic              pair_err;

    // Decide whether the current violation is a codeword or an error.
    always_comb begin
        e3_act   = cfg_hdb3 & cfg_e3;
        need_z   = cfg_hdb3 ? ZRUN_W'(2) : ZRUN_W'(1);
        shape_ok = (info.zrun >= need_z);
        pol_ok   = ~cw_seen | ~cfg_track | (info.neg != cw_neg);
        is_cw    = info.is_bpv & shape_ok & pol_ok;
        pair_err = info.is_bpv & v_seen & (info.neg == v_neg);
        err      = e3_act ? pair_err : (info.is_bpv & ~is_cw);
    end

    // Remember the polarity of the last accepted codeword and last violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cw_seen <= 1'b0;
            cw_neg  <= 1'b0;
            v_seen  <= 1'b0;
            v_neg   <= 1'b0;
        end else begin
            if (is_cw) begin
                cw_seen <= 1'b1;
                cw_neg  <= info.neg;
            end
            if (info.is_bpv) begin
                v_seen <= 1'b1;
                v_neg  <= info.neg;
            end
        end
    end

    // Only a violation can ever be an error (R2).
    p_err_is_bpv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> info.is_bpv);

    // Simple 3-zero rule: a violation after a zero is never counted (R2).
    p_b3_cw_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_hdb3 && !cfg_track && info.is_bpv && info.zrun != '0) |-> !err);

    // Same-polarity mode needs an earlier violation to pair with (R6).
    p_e3_needs_prior_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (e3_act && err) |-> v_seen);
endmodule

// File: rtl/bpvm_sat_counter.sv
// Module: bpvm_sat_counter
// Saturating event counter with a latch strobe that copies the running count
// to a holding register and restarts it; an event in the latch cycle seeds
// the new period. Assumes inc and latch are single-clock qualified.
module bpvm_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             latch,
    output logic [CNT_W-1:0] held
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run;

    // Advance, saturate, or restart the running count; capture on latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= '0;
            held <= '0;
        end else if (latch) begin
            held <= run;
            run  <= inc ? CNT_W'(1) : '0;
        end else if (inc && run != CNT_MAX) begin
            run <= run + 1'b1;
        end
    end

    // Count holds at all ones (R9).
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run == CNT_MAX && !latch) |=> run == CNT_MAX);

    // After a latch the new period holds at most the coincident event (R10).
    p_latch_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> run <= CNT_W'(1));

    // The holding output moves only on a latch (R10).
    p_held_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !latch |=> $stable(held));
endmodule

// File: rtl/bpv_err_monitor.sv
// Module: bpv_err_monitor
// Top of the bipolar line error counter: symbol tracking, codeword filtering,
// error pulse and saturating latched count.
// Assumes: synchronous active-low reset; configuration is quasi-static.
module bpv_err_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             rail_p,
    input  logic             rail_n,
    input  logic             cfg_hdb3,
    input  logic             cfg_track,
    input  logic             cfg_e3,
    input  logic             latch_stb,
    output logic             err_pulse,
    output logic [CNT_W-1:0] held_count
);
    import bpvm_pkg::*;

    slot_info_t info;
    logic       err;

    bpvm_symbol_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .rail_p    (rail_p),
        .rail_n    (rail_n),
        .info      (info)
    );

    bpvm_cw_filter u_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .info      (info),
        .cfg_hdb3  (cfg_hdb3),
        .cfg_track (cfg_track),
        .cfg_e3    (cfg_e3),
        .err       (err)
    );

    bpvm_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (err),
        .latch (latch_stb),
        .held  (held_count)
    );

    // Register the per-slot error into a one-clock pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= err;
    end

    // A pulse always follows a valid slot (R8).
    p_pulse_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(sym_valid));
endmodule

// File: tb/tb_bpv_err_monitor.sv
module tb_bpv_err_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sym_valid = 1'b0, rail_p = 1'b0, rail_n = 1'b0;
    logic        cfg_hdb3 = 1'b0, cfg_track = 1'b0, cfg_e3 = 1'b0, latch_stb = 1'b0;
    logic        err_pulse;
    logic [15:0] held_count;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz

    bpv_err_monitor dut (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .rail_p(rail_p),
        .rail_n(rail_n), .cfg_hdb3(cfg_hdb3), .cfg_track(cfg_track),
        .cfg_e3(cfg_e3), .latch_stb(latch_stb), .err_pulse(err_pulse),
        .held_count(held_count)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reset with given mode; returns at a negedge with inputs idle.
    task automatic do_reset(input logic h, input logic t, input logic e);
        @(negedge clk);
        rst_n = 1'b0; sym_valid = 1'b0; rail_p = 1'b0; rail_n = 1'b0; latch_stb = 1'b0;
        cfg_hdb3 = h; cfg_track = t; cfg_e3 = e;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One valid slot; checks the pulse one clock later. s: +1, -1, 0, 2 (both rails).
    task automatic send(input int s, input logic exp, input string tag);
        sym_valid = 1'b1;
        rail_p = (s == 1 || s == 2);
        rail_n = (s == -1 || s == 2);
        @(negedge clk);
        chk(int'(err_pulse), int'(exp), tag);
    endtask

    task automatic latch_chk(input int exp, input string tag);
        sym_valid = 1'b0; latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0;
        chk(int'(held_count), exp, tag);
    endtask

    task automatic t_reset_r11;
        do_reset(1'b0, 1'b0, 1'b0);
        chk(int'(held_count), 0, "R11 held after reset");
        chk(int'(err_pulse), 0, "R11 pulse after reset");
        latch_chk(0, "R11 running count after reset");
    endtask

    task automatic t_basic_r1_r8;
        do_reset(1'b0, 1'b0, 1'b0);
        send(1, 0, "R1 first mark");
        send(-1, 0, "R1 alternate");
        send(1, 0, "R1 alternate");
        send(-1, 0, "R1 alternate");
        send(1, 0, "R1 alternate");
        send(1, 1, "R1 same polarity pair");
        send(2, 0, "R1 both rails is zero");
        send(1, 0, "R1 zero then violation is codeword");
        // a negative mark with sym_valid low must be ignored
        sym_valid = 1'b0; rail_p = 1'b0; rail_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(int'(err_pulse), 0, "R8 no pulse without slot");
        end
        send(1, 1, "R8 invalid mark left history alone");
        latch_chk(2, "R8 count of basic stream");
    endtask

    task automatic t_b3zs_r2;
        do_reset(1'b0, 1'b0, 1'b0);
        send(1, 0, "R2 mark");
        send(0, 0, "R2 zero");
        send(1, 0, "R2 B0V codeword");
        send(0, 0, "R2 zero");
        send(0, 0, "R2 zero");
        send(1, 0, "R2 longer run codeword");
        send(1, 1, "R2 bare violation");
        send(-1, 0, "R2 alternate");
        send(-1, 1, "R2 bare violation neg");
        latch_chk(2, "R2 count");
    endtask

    task automatic t_hdb3_r3;
        do_reset(1'b1, 1'b0, 1'b0);
        send(1, 0, "R3 mark");
        send(0, 0, "R3 zero");
        send(1, 1, "R3 one zero is not enough");
        send(0, 0, "R3 zero");
        send(0, 0, "R3 zero");
        send(1, 0, "R3 two-zero codeword");
        send(0, 0, "R3 zero");
        send(0, 0, "R3 zero");
        send(0, 0, "R3 zero");
        send(1, 0, "R3 three-zero codeword");
        latch_chk(1, "R3 count");
    endtask

    task automatic t_track_r4_r5;
        do_reset(1'b0, 1'b1, 1'b0);
        send(-1, 0, "R5 mark");
        send(0, 0, "R5 zero");
        send(-1, 0, "R5 first codeword any polarity");
        send(0, 0, "R4 zero");
        send(-1, 1, "R4 same-polarity codeword counted");
        send(1, 0, "R4 mark");
        send(0, 0, "R4 zero");
        send(1, 0, "R4 opposite codeword accepted");
        send(0, 0, "R4 zero");
        send(1, 1, "R4 repeat polarity counted");
        send(-1, 0, "R4 mark");
        send(0, 0, "R4 zero");
        send(-1, 0, "R4 opposite codeword accepted");
        latch_chk(2, "R4 count");
        do_reset(1'b0, 1'b1, 1'b0);
        send(1, 0, "R5 mark");
        send(0, 0, "R5 zero");
        send(1, 0, "R5 first codeword positive");
        latch_chk(0, "R5 count");
    endtask

    task automatic t_e3_r6;
        do_reset(1'b1, 1'b0, 1'b1);
        send(1, 0, "R6 mark");
        send(0, 0, "R6 zero");
        send(0, 0, "R6 zero");
        send(1, 0, "R6 first violation");
        send(-1, 0, "R6 mark");
        send(0, 0, "R6 zero");
        send(0, 0, "R6 zero");
        send(-1, 0, "R6 alternating violation");
        send(1, 0, "R6 mark");
        send(1, 0, "R6 bare violation alternating");
        send(1, 1, "R6 same-polarity violation pair");
        latch_chk(1, "R6 count");
    endtask

    task automatic t_e3_ignored_r7;
        do_reset(1'b0, 1'b0, 1'b1);
        send(1, 0, "R7 mark");
        send(1, 1, "R7 violation counted in 3-zero mode");
        send(1, 1, "R7 violation counted in 3-zero mode");
        latch_chk(2, "R7 count");
    endtask

    task automatic t_latch_r10;
        do_reset(1'b0, 1'b0, 1'b0);
        send(1, 0, "R10 mark");
        send(1, 1, "R10 violation");
        sym_valid = 1'b1; rail_p = 1'b1; rail_n = 1'b0; latch_stb = 1'b1;
        @(negedge clk);
        latch_stb = 1'b0; sym_valid = 1'b0;
        chk(int'(err_pulse), 1, "R10 pulse in latch slot");
        chk(int'(held_count), 1, "R10 held excludes coincident error");
        repeat (2) @(negedge clk);
        chk(int'(held_count), 1, "R10 held stable between latches");
        latch_chk(1, "R10 coincident error in new period");
        latch_chk(0, "R10 empty period");
    endtask

    task automatic t_sat_r9;
        do_reset(1'b0, 1'b0, 1'b0);
        sym_valid = 1'b1; rail_p = 1'b1; rail_n = 1'b0;
        repeat (65541) @(negedge clk);
        chk(int'(err_pulse), 1, "R9 pulses continue at saturation");
        latch_chk(65535, "R9 saturated count");
        latch_chk(0, "R9 cleared after latch");
    endtask

    initial begin
        t_reset_r11();
        t_basic_r1_r8();
        t_b3zs_r2();
        t_hdb3_r3();
        t_track_r4_r5();
        t_e3_r6();
        t_e3_ignored_r7();
        t_latch_r10();
        t_sat_r9();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule